// File: doc/BRIEF.md
# Gate Driver Protection Controller

This block is the synchronous control core of a single-channel isolated gate driver. It receives two PWM commands (one non-inverting, one inverting), an enable pin whose low level also acts as a fault-clear request, an overcurrent comparator flag and two supply-good comparator flags, one for the logic side and one for the drive side. It produces exactly one of three drive commands at a time: turn on, normal (hard) turn-off, or soft turn-off. It also produces an active-low fault flag and a ready flag. Every input first passes through its own deglitch filter. All durations are parameters counted in cycles of one clock, 10 ns per cycle by default.

An overcurrent flag that stays high for the overcurrent filter time latches a fault. The fault drives the power switch off through the soft path and pulls the fault flag low. A short low on the enable pin only turns the switch off. The latched fault clears only on the rising edge that ends a low lasting at least the long-low time, and only once the mute time since the fault was recognised has run out. A rising edge that arrives too early leaves the fault latched, and a new long low is needed. Ready falls whenever either filtered supply flag is low. After a drive-side dropout, ready stays low for an extra hold time.

Top module: `gate_drive_ctrl`

## Requirements
- R1: Synchronous active-high reset gives drv_hard_off_o=1, drv_on_o=0, drv_soft_off_o=0, fault_n_o=1, ready_o=0.
- R2: drv_on_o is 1 only when the filtered pwm_pos_i=1, pwm_neg_i=0, enable_i=1, both supplies are good and no fault is latched or being recognised. A change on a PWM pin reaches drv_on_o IN_FILT+1 cycles later.
- R3: A pulse on pwm_pos_i, pwm_neg_i or enable_i that lasts fewer than IN_FILT cycles leaves every output unchanged. The same holds for an oc_i pulse that lasts fewer than OC_FILT cycles.
- R4: When the filtered enable_i is low, drv_hard_off_o is 1, whether or not a fault is latched.
- R5: oc_i held high for OC_FILT cycles latches a fault. fault_n_o falls and drv_soft_off_o rises (if enabled and supplied) OC_FILT+1 cycles after oc_i rises.
- R6: A latched fault clears, and fault_n_o returns to 1, IN_FILT+1 cycles after the rising edge of enable_i. This happens only if the filtered enable_i was low for at least RST_LONG cycles just before that edge. A shorter low leaves the fault latched.
- R7: A rising edge of enable_i that comes fewer than MUTE cycles after fault recognition does not clear the fault.
- R8: ready_o is 0 while either filtered supply flag is low. Otherwise it is 1, except during the hold of R9. Filter lengths: VCC_FILT cycles for vcc_good_i, VDD_FILT cycles for vdd_good_i.
- R9: After the filtered vdd_good_i returns high, ready_o stays low for HOLD more cycles and rises on the following one.
- R10: While either filtered supply flag is low, drv_on_o is 0 and drv_hard_off_o is 1.
- R11: Exactly one of drv_on_o, drv_hard_off_o and drv_soft_off_o is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_pos_i | input | 1 | Non-inverting PWM command |
| pwm_neg_i | input | 1 | Inverting PWM command |
| enable_i | input | 1 | Enable; a long low requests fault clear |
| oc_i | input | 1 | Overcurrent comparator flag |
| vcc_good_i | input | 1 | Logic-side supply above lockout threshold |
| vdd_good_i | input | 1 | Drive-side supply above lockout threshold |
| drv_on_o | output | 1 | Turn-on command |
| drv_hard_off_o | output | 1 | Normal turn-off command |
| drv_soft_off_o | output | 1 | Soft turn-off command |
| fault_n_o | output | 1 | Active-low latched fault flag |
| ready_o | output | 1 | Both supplies good and hold elapsed |

## Verification
A change on any pin passes through its filter, taking the filter length in cycles, and then through one more register. The drive commands therefore follow a PWM or enable change after IN_FILT+1 cycles and an overcurrent after OC_FILT+1 cycles. Fault clear lands IN_FILT+1 cycles after enable rises. Ready rises HOLD+1 cycles after the filtered drive-side supply flag recovers. The bench drives pins on the falling clock edge and runs a behavioural model of these delays on the rising edge. It compares every output on each falling edge. Directed checks sample one cycle before and exactly at each due cycle, so a result that comes one cycle early or one cycle late is caught.

// File: rtl/gdp_pkg.sv
package gdp_pkg;

    // Positions of the deglitched inputs inside the filter vector
    localparam int SIG_POS  = 0;
    localparam int SIG_NEG  = 1;
    localparam int SIG_EN   = 2;
    localparam int SIG_OC   = 3;
    localparam int SIG_VCC  = 4;
    localparam int SIG_VDD  = 5;
    localparam int SIG_NUM  = 6;

    typedef enum logic [1:0] {
        DRV_OFF  = 2'd0,
        DRV_ON   = 2'd1,
        DRV_SOFT = 2'd2
    } drv_e;

    typedef struct packed {
        logic vdd_ok;
        logic vcc_ok;
        logic oc;
        logic enable;
        logic pwm_neg;
        logic pwm_pos;
    } flt_in_t;

    // Drive decision: lockout and disable win, then fault, then PWM.
    function automatic drv_e next_drive(flt_in_t f, logic faulted);
        drv_e d;
        if (!f.enable || !f.vcc_ok || !f.vdd_ok)
            d = DRV_OFF;
        else if (faulted || f.oc)
            d = DRV_SOFT;
        else if (f.pwm_pos && !f.pwm_neg)
            d = DRV_ON;
        else
            d = DRV_OFF;
        return d;
    endfunction

endpackage

// File: rtl/gdp_deglitch.sv
module gdp_deglitch #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= 1'b0;
            run_cnt <= '0;
        end else if (d != q) begin
            if (run_cnt == CW'(CYC - 1)) begin
                q       <= d;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end

    // Output only ever moves to the value the input held at that edge
    AST_FILT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (rst)
        !$stable(q) |-> ($past(d) == q)); // R3

endmodule

// File: rtl/gdp_fault.sv
module gdp_fault #(
    parameter int RST_LONG = 100,
    parameter int MUTE     = 55000
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_f,
    input  logic en_f,
    output logic fault_q
);
    localparam int LW = $clog2(RST_LONG + 1);
    localparam int MW = $clog2(MUTE + 1);

    logic [LW-1:0] low_cnt;
    logic [MW-1:0] mute_cnt;
    logic          clear_ok;

    // Rising enable edge after a long enough low, mute time spent
    assign clear_ok = en_f && (low_cnt == LW'(RST_LONG)) && (mute_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (en_f) begin
            low_cnt <= '0;
        end else if (low_cnt != LW'(RST_LONG)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q  <= 1'b0;
            mute_cnt <= '0;
        end else if (oc_f) begin
            fault_q  <= 1'b1;
            mute_cnt <= MW'(MUTE);
        end else begin
            if (fault_q && clear_ok)
                fault_q <= 1'b0;
            if (mute_cnt != '0)
                mute_cnt <= mute_cnt - 1'b1;
        end
    end

    AST_OC_LATCHES: assert property (@(posedge clk) disable iff (rst)
        oc_f |=> fault_q); // R5

    AST_CLEAR_NEEDS_LONG_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_q) |-> ($past(low_cnt) == LW'(RST_LONG))); // R6

    AST_CLEAR_AFTER_MUTE: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_q) |-> ($past(mute_cnt) == '0)); // R7

endmodule

// File: rtl/gdp_supply.sv
module gdp_supply #(
    parameter int HOLD = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic vcc_f,
    input  logic vdd_f,
    output logic ready_q
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
            ready_q  <= 1'b0;
        end else begin
            if (!vdd_f)
                hold_cnt <= HW'(HOLD);
            else if (hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
            ready_q <= vcc_f && vdd_f && (hold_cnt == '0);
        end
    end

    AST_READY_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        ready_q |-> $past(vcc_f && vdd_f)); // R8

    AST_HOLD_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst)
        (hold_cnt != '0) |=> !ready_q); // R9

endmodule

// File: rtl/gate_drive_ctrl.sv
module gate_drive_ctrl
    import gdp_pkg::*;
#(
    parameter int IN_FILT  = 4,
    parameter int OC_FILT  = 12,
    parameter int VCC_FILT = 1000,
    parameter int VDD_FILT = 500,
    parameter int RST_LONG = 100,
    parameter int MUTE     = 55000,
    parameter int HOLD     = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_pos_i,
    input  logic pwm_neg_i,
    input  logic enable_i,
    input  logic oc_i,
    input  logic vcc_good_i,
    input  logic vdd_good_i,
    output logic drv_on_o,
    output logic drv_hard_off_o,
    output logic drv_soft_off_o,
    output logic fault_n_o,
    output logic ready_o
);
    logic [SIG_NUM-1:0] raw;
    logic [SIG_NUM-1:0] filt;
    flt_in_t            fin;
    logic               fault_q;
    drv_e               drv_q;

    assign raw[SIG_POS] = pwm_pos_i;
    assign raw[SIG_NEG] = pwm_neg_i;
    assign raw[SIG_EN]  = enable_i;
    assign raw[SIG_OC]  = oc_i;
    assign raw[SIG_VCC] = vcc_good_i;
    assign raw[SIG_VDD] = vdd_good_i;

    generate
        for (genvar g = 0; g < SIG_NUM; g++) begin : g_filt
            localparam int LEN = (g == SIG_OC)  ? OC_FILT  :
                                 (g == SIG_VCC) ? VCC_FILT :
                                 (g == SIG_VDD) ? VDD_FILT : IN_FILT;
            gdp_deglitch #(.CYC(LEN)) u_dg (
                .clk (clk),
                .rst (rst),
                .d   (raw[g]),
                .q   (filt[g])
            );
        end
    endgenerate

    assign fin.pwm_pos = filt[SIG_POS];
    assign fin.pwm_neg = filt[SIG_NEG];
    assign fin.enable  = filt[SIG_EN];
    assign fin.oc      = filt[SIG_OC];
    assign fin.vcc_ok  = filt[SIG_VCC];
    assign fin.vdd_ok  = filt[SIG_VDD];

    gdp_fault #(.RST_LONG(RST_LONG), .MUTE(MUTE)) u_fault (
        .clk     (clk),
        .rst     (rst),
        .oc_f    (fin.oc),
        .en_f    (fin.enable),
        .fault_q (fault_q)
    );

    gdp_supply #(.HOLD(HOLD)) u_supply (
        .clk     (clk),
        .rst     (rst),
        .vcc_f   (fin.vcc_ok),
        .vdd_f   (fin.vdd_ok),
        .ready_q (ready_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            drv_q <= DRV_OFF;
        else
            drv_q <= next_drive(fin, fault_q);
    end

    assign drv_on_o       = (drv_q == DRV_ON);
    assign drv_hard_off_o = (drv_q == DRV_OFF);
    assign drv_soft_off_o = (drv_q == DRV_SOFT);
    assign fault_n_o      = !fault_q;

    AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (rst)
        $onehot({drv_on_o, drv_hard_off_o, drv_soft_off_o})); // R11

    AST_FAULT_BLOCKS_ON: assert property (@(posedge clk) disable iff (rst)
        fault_q |-> !drv_on_o); // R5

    AST_LOCKOUT_OFF: assert property (@(posedge clk) disable iff (rst)
        !(fin.vcc_ok && fin.vdd_ok) |=> (drv_hard_off_o && !drv_on_o)); // R10

    AST_DISABLE_HARD: assert property (@(posedge clk) disable iff (rst)
        !fin.enable |=> drv_hard_off_o); // R4

endmodule

// File: tb/test_gate_drive_ctrl.sv
`timescale 1ns/1ps
module test_gate_drive_ctrl;
    localparam int IN_FILT  = 4;
    localparam int OC_FILT  = 12;
    localparam int VCC_FILT = 50;
    localparam int VDD_FILT = 30;
    localparam int RST_LONG = 100;
    localparam int MUTE     = 300;
    localparam int HOLD     = 200;
    localparam int FLEN [6] = '{IN_FILT, IN_FILT, IN_FILT, OC_FILT, VCC_FILT, VDD_FILT};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm_pos = 1'b0, pwm_neg = 1'b0, en = 1'b1, oc = 1'b0, vcc = 1'b1, vdd = 1'b1;
    logic drv_on, drv_hard, drv_soft, fault_n, ready;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gate_drive_ctrl #(
        .IN_FILT(IN_FILT), .OC_FILT(OC_FILT), .VCC_FILT(VCC_FILT), .VDD_FILT(VDD_FILT),
        .RST_LONG(RST_LONG), .MUTE(MUTE), .HOLD(HOLD)
    ) i_gate_drive_ctrl (
        .clk(clk), .rst(rst), .pwm_pos_i(pwm_pos), .pwm_neg_i(pwm_neg), .enable_i(en),
        .oc_i(oc), .vcc_good_i(vcc), .vdd_good_i(vdd),
        .drv_on_o(drv_on), .drv_hard_off_o(drv_hard), .drv_soft_off_o(drv_soft),
        .fault_n_o(fault_n), .ready_o(ready)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Behavioural reference: filtered pin values, run lengths, counters
    logic [5:0] mf;
    int         mc [6];
    int         m_drv;     // 0 hard off, 1 on, 2 soft off
    bit         m_fault, m_ready;
    int         m_good, m_low, m_since;

    always @(posedge clk) begin
        logic [5:0] pins;
        pins = {vdd, vcc, oc, en, pwm_neg, pwm_pos};
        if (rst) begin
            mf = '0;
            for (int i = 0; i < 6; i++) mc[i] = 0;
            m_drv = 0; m_fault = 0; m_ready = 0;
            m_good = 0; m_low = 0; m_since = MUTE;
        end else begin
            if (!mf[2] || !mf[4] || !mf[5])      m_drv = 0;
            else if (m_fault || mf[3])          m_drv = 2;
            else if (mf[0] && !mf[1])           m_drv = 1;
            else                                m_drv = 0;
            m_good  = mf[5] ? ((m_good < 1000000) ? m_good + 1 : m_good) : 0;
            m_ready = mf[4] && mf[5] && (m_good >= HOLD + 1);
            if (mf[3]) begin
                m_fault = 1; m_since = 0;
            end else begin
                if (m_fault && mf[2] && m_low >= RST_LONG && m_since >= MUTE) m_fault = 0;
                if (m_since < 1000000) m_since++;
            end
            m_low = mf[2] ? 0 : m_low + 1;
            for (int i = 0; i < 6; i++) begin
                if (pins[i] != mf[i]) begin
                    mc[i]++;
                    if (mc[i] == FLEN[i]) begin mf[i] = pins[i]; mc[i] = 0; end
                end else begin
                    mc[i] = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("R2 on",      drv_on,   m_drv == 1);
            check("R4 hard",    drv_hard, m_drv == 0);
            check("R5 soft",    drv_soft, m_drv == 2);
            check("R6 fault_n", fault_n,  !m_fault);
            check("R8 ready",   ready,    m_ready);
            check("R11 onehot", $onehot({drv_on, drv_hard, drv_soft}), 1'b1);
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        cmp_on = 1'b1;
        // R1 reset state
        check("R1 on", drv_on, 1'b0);
        check("R1 hard", drv_hard, 1'b1);
        check("R1 soft", drv_soft, 1'b0);
        check("R1 fault_n", fault_n, 1'b1);
        check("R1 ready", ready, 1'b0);
        rst = 1'b0;
        // R9 power-up: ready HOLD+1 cycles after filtered vdd good
        wait_n(VDD_FILT + HOLD);
        check("R9 ready early", ready, 1'b0);
        wait_n(1);
        check("R9 ready due", ready, 1'b1);
        wait_n(30);
        // R2 turn on timing
        pwm_pos = 1'b1;
        wait_n(IN_FILT);
        check("R2 on early", drv_on, 1'b0);
        wait_n(1);
        check("R2 on due", drv_on, 1'b1);
        // R3 short pulses
        pwm_pos = 1'b0; wait_n(IN_FILT - 1); pwm_pos = 1'b1; wait_n(10);
        check("R3 pos glitch", drv_on, 1'b1);
        en = 1'b0; wait_n(IN_FILT - 1); en = 1'b1; wait_n(10);
        check("R3 en glitch", drv_on, 1'b1);
        pwm_neg = 1'b1; wait_n(IN_FILT - 1); pwm_neg = 1'b0; wait_n(10);
        check("R3 neg glitch", drv_on, 1'b1);
        // R2 inverting input
        pwm_neg = 1'b1; wait_n(IN_FILT + 1);
        check("R2 neg off", drv_on, 1'b0);
        check("R2 neg hard", drv_hard, 1'b1);
        pwm_neg = 1'b0; wait_n(IN_FILT + 1);
        check("R2 back on", drv_on, 1'b1);
        // R4 disable
        en = 1'b0; wait_n(IN_FILT + 1);
        check("R4 disabled", drv_hard, 1'b1);
        wait_n(20); en = 1'b1; wait_n(IN_FILT + 1);
        check("R4 re-enabled", drv_on, 1'b1);
        // R3 short overcurrent
        oc = 1'b1; wait_n(OC_FILT - 1); oc = 1'b0; wait_n(20);
        check("R3 oc glitch", fault_n, 1'b1);
        check("R3 oc glitch on", drv_on, 1'b1);
        // R5 fault recognition
        oc = 1'b1; wait_n(OC_FILT);
        check("R5 fault early", fault_n, 1'b1);
        wait_n(1);
        check("R5 fault due", fault_n, 1'b0);
        check("R5 soft", drv_soft, 1'b1);
        oc = 1'b0;
        // R4 with fault pending, R7 early clear ignored
        en = 1'b0; wait_n(IN_FILT + 1);
        check("R4 hard in fault", drv_hard, 1'b1);
        check("R4 fault kept", fault_n, 1'b0);
        wait_n(RST_LONG + 20); en = 1'b1; wait_n(10);
        check("R7 muted", fault_n, 1'b0);
        check("R7 soft", drv_soft, 1'b1);
        wait_n(MUTE);
        // R6 short low does not clear
        en = 1'b0; wait_n(RST_LONG / 2); en = 1'b1; wait_n(10);
        check("R6 short low", fault_n, 1'b0);
        // R6 long low clears on rising edge
        en = 1'b0; wait_n(RST_LONG + 20); en = 1'b1;
        wait_n(IN_FILT);
        check("R6 clear early", fault_n, 1'b0);
        wait_n(1);
        check("R6 clear due", fault_n, 1'b1);
        wait_n(1);
        check("R6 on again", drv_on, 1'b1);
        // R10 input-side lockout
        vcc = 1'b0; wait_n(VCC_FILT);
        check("R8 ready before", ready, 1'b1);
        wait_n(1);
        check("R8 vcc low", ready, 1'b0);
        check("R10 vcc hard", drv_hard, 1'b1);
        vcc = 1'b1; wait_n(VCC_FILT + 1);
        check("R8 vcc back", ready, 1'b1);
        // R9 output-side dropout hold
        vdd = 1'b0; wait_n(VDD_FILT + 1);
        check("R8 vdd low", ready, 1'b0);
        check("R10 vdd off", drv_on, 1'b0);
        wait_n(9); vdd = 1'b1;
        wait_n(VDD_FILT + HOLD);
        check("R9 hold early", ready, 1'b0);
        wait_n(1);
        check("R9 hold due", ready, 1'b1);
        check("R10 on after", drv_on, 1'b1);
        wait_n(5);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule